// File: doc/BRIEF.md
# Speculative Key/Value Page Table

This block is a small associative table that translates a key made of sequence id, layer and token position into the physical page that holds one token's key/value data. Every entry belongs either to the committed state or to one speculative branch of a draft token tree. Each speculative entry carries a 6-bit branch id. A lookup names the branch it speaks for. It sees all committed entries and only the speculative entries of its own branch.

Tree branches share committed prefix pages through a copy-on-write bit. Marking a page as shared costs no storage. A branch that later updates a shared page receives a private page from the free list. Once the verifier has decided, one transaction command with a 64-bit branch mask commits or discards every speculative entry of the masked branches in a single cycle. Discarded pages go back to the free list in that same cycle, and their contents are not touched.

Top module: `kv_page_table`

## Requirements
- R1: After reset the table holds no entries, the free count equals PAGES, and every lookup misses.
- R2: A lookup answers one cycle after the request with lkp_done_o high. On a miss, lkp_hit_o is low. On a hit, the port returns the page number and its byte address, which is the page number times 4096.
- R3: Write op 0 (allocate) takes the lowest-numbered free page and creates a speculative entry for the requesting branch. Only that branch can see the entry.
- R4: Write op 1 (share) sets the copy-on-write bit of the committed entry for the key. It uses no page, and lookups then report lkp_cow_o high.
- R5: Write op 2 (update) handles three cases. On a committed copy-on-write entry it allocates a private page for the branch, and other branches keep seeing the shared page. On the branch's own speculative entry, or on a committed entry without copy-on-write, it uses no page and returns the existing page.
- R6: A commit (txn_commit_i=1) turns every speculative entry whose branch bit is set in txn_mask_i into a committed entry, which all branches see with lkp_spec_o low. Unmasked entries are unchanged. A committed entry with the same key is replaced, and its page is freed.
- R7: A rollback (txn_commit_i=0) removes every speculative entry of the masked branches. Their pages return to the free list in the same cycle. Committed entries and unmasked branches are untouched.
- R8: When a key exists both committed and speculative for the requesting branch, the lookup returns the speculative entry.
- R9: A write is refused with wr_err_o and changes no state when any of these holds: no page is free, no entry is free, an allocate names a key the branch can already see, a share or update finds no visible entry, op 3 is used, or a transaction is issued in the same cycle.
- R10: free_cnt_o always equals the number of free physical pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_seq_i | input | SEQ_W | Lookup sequence id |
| lkp_layer_i | input | LAYER_W | Lookup layer |
| lkp_pos_i | input | POS_W | Lookup token position |
| lkp_branch_i | input | BR_W | Branch the lookup speaks for |
| lkp_done_o | output | 1 | Lookup result valid |
| lkp_hit_o | output | 1 | Entry found |
| lkp_spec_o | output | 1 | Found entry is speculative |
| lkp_cow_o | output | 1 | Found entry is copy-on-write |
| lkp_page_o | output | PG_W | Physical page number |
| lkp_addr_o | output | PG_W+12 | Page byte address |
| wr_valid_i | input | 1 | Write request |
| wr_op_i | input | 2 | 0 allocate, 1 share, 2 update, 3 reserved |
| wr_seq_i | input | SEQ_W | Write sequence id |
| wr_layer_i | input | LAYER_W | Write layer |
| wr_pos_i | input | POS_W | Write token position |
| wr_branch_i | input | BR_W | Requesting branch |
| wr_ack_o | output | 1 | Write accepted (one cycle later) |
| wr_err_o | output | 1 | Write refused (one cycle later) |
| wr_page_o | output | PG_W | Page used by an accepted write |
| txn_valid_i | input | 1 | Transaction command |
| txn_commit_i | input | 1 | 1 commit, 0 rollback |
| txn_mask_i | input | 2**BR_W | Branch mask |
| free_cnt_o | output | clog2(PAGES+1) | Free page count |

## Verification
The bench builds the table with ENTRIES=4 and PAGES=4, and keeps BR_W at 6. With these sizes the fourth allocation fills both the table and the free list at once, so the refusal path is reached after a few operations. Freed pages are then handed out again in lowest-first order. Because BR_W stays at its full width, the 64-bit mask is exercised up to branch 63. Commits that replace a shared committed page, and rollbacks that mix masked and unmasked branches, both fit within those four slots.

// File: rtl/kvpt_pkg.sv
package kvpt_pkg;
  typedef enum logic [1:0] {
    WR_ALLOC  = 2'd0,
    WR_SHARE  = 2'd1,
    WR_UPDATE = 2'd2,
    WR_RSVD   = 2'd3
  } wr_op_e;

  localparam int PAGE_LG_BYTES = 12;
endpackage

// File: rtl/kvpt_pick.sv
module kvpt_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/kvpt_cam.sv
module kvpt_cam #(
  parameter int N     = 16,
  parameter int KEY_W = 22,
  parameter int BR_W  = 6
) (
  input  logic [N-1:0]     vld_i,
  input  logic [N-1:0]     spec_i,
  input  logic [KEY_W-1:0] key_i [N],
  input  logic [BR_W-1:0]  br_i  [N],
  input  logic [KEY_W-1:0] q_key_i,
  input  logic [BR_W-1:0]  q_br_i,
  output logic [N-1:0]     spec_hit_o,
  output logic [N-1:0]     cmt_hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic match;
    assign match         = vld_i[i] && (key_i[i] == q_key_i);
    assign spec_hit_o[i] = match && spec_i[i] && (br_i[i] == q_br_i);
    assign cmt_hit_o[i]  = match && !spec_i[i];
  end
endmodule

// File: rtl/kvpt_free_pool.sv
module kvpt_free_pool #(
  parameter int PAGES = 32,
  parameter int PG_W  = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [PAGES-1:0] release_i,
  input  logic [CNT_W-1:0] release_cnt_i,
  output logic [PG_W-1:0]  page_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [PAGES-1:0] free_q, take_vec;
  logic [CNT_W-1:0] cnt_q;
  logic             any;

  kvpt_pick #(.N(PAGES), .IDX_W(PG_W)) u_pick (
    .vec_i(free_q), .idx_o(page_o), .any_o(any)
  );

  assign empty_o = !any;
  assign count_o = cnt_q;

  always_comb begin
    take_vec = '0;
    if (take_i && any) take_vec[page_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= '1;
      cnt_q  <= CNT_W'(PAGES);
    end else begin
      free_q <= (free_q & ~take_vec) | release_i;
      cnt_q  <= cnt_q - CNT_W'(take_i && any) + release_cnt_i;
    end
  end

  // R10
  count_matches_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_W'($countones(free_q)));
  // R7
  no_double_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i & free_q) == '0);
  // R9
  take_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> any);
endmodule

// File: rtl/kv_page_table.sv
module kv_page_table
  import kvpt_pkg::*;
#(
  parameter int SEQ_W   = 4,
  parameter int LAYER_W = 6,
  parameter int POS_W   = 12,
  parameter int BR_W    = 6,
  parameter int ENTRIES = 16,
  parameter int PAGES   = 32,
  localparam int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CNT_W  = $clog2(PAGES + 1),
  localparam int NBR    = 1 << BR_W,
  localparam int ADDR_W = PG_W + PAGE_LG_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lkp_valid_i,
  input  logic [SEQ_W-1:0]   lkp_seq_i,
  input  logic [LAYER_W-1:0] lkp_layer_i,
  input  logic [POS_W-1:0]   lkp_pos_i,
  input  logic [BR_W-1:0]    lkp_branch_i,
  output logic               lkp_done_o,
  output logic               lkp_hit_o,
  output logic               lkp_spec_o,
  output logic               lkp_cow_o,
  output logic [PG_W-1:0]    lkp_page_o,
  output logic [ADDR_W-1:0]  lkp_addr_o,
  input  logic               wr_valid_i,
  input  logic [1:0]         wr_op_i,
  input  logic [SEQ_W-1:0]   wr_seq_i,
  input  logic [LAYER_W-1:0] wr_layer_i,
  input  logic [POS_W-1:0]   wr_pos_i,
  input  logic [BR_W-1:0]    wr_branch_i,
  output logic               wr_ack_o,
  output logic               wr_err_o,
  output logic [PG_W-1:0]    wr_page_o,
  input  logic               txn_valid_i,
  input  logic               txn_commit_i,
  input  logic [NBR-1:0]     txn_mask_i,
  output logic [CNT_W-1:0]   free_cnt_o
);
  localparam int KEY_W = SEQ_W + LAYER_W + POS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry state
  logic [ENTRIES-1:0] vld_q, spec_q, cow_q;
  logic [KEY_W-1:0]   key_q  [ENTRIES];
  logic [BR_W-1:0]    br_q   [ENTRIES];
  logic [PG_W-1:0]    page_q [ENTRIES];

  logic [KEY_W-1:0] lkp_key, wr_key;
  assign lkp_key = {lkp_seq_i, lkp_layer_i, lkp_pos_i};
  assign wr_key  = {wr_seq_i, wr_layer_i, wr_pos_i};

  // lookup match
  logic [ENTRIES-1:0] l_spec_hit, l_cmt_hit;
  logic [IDX_W-1:0]   l_spec_idx, l_cmt_idx;
  logic               l_spec_any, l_cmt_any;

  kvpt_cam #(.N(ENTRIES), .KEY_W(KEY_W), .BR_W(BR_W)) u_lkp_cam (
    .vld_i(vld_q), .spec_i(spec_q), .key_i(key_q), .br_i(br_q),
    .q_key_i(lkp_key), .q_br_i(lkp_branch_i),
    .spec_hit_o(l_spec_hit), .cmt_hit_o(l_cmt_hit)
  );
  kvpt_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_lkp_spec_pick (
    .vec_i(l_spec_hit), .idx_o(l_spec_idx), .any_o(l_spec_any)
  );
  kvpt_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_lkp_cmt_pick (
    .vec_i(l_cmt_hit), .idx_o(l_cmt_idx), .any_o(l_cmt_any)
  );

  // write match
  logic [ENTRIES-1:0] w_spec_hit, w_cmt_hit;
  logic [IDX_W-1:0]   w_spec_idx, w_cmt_idx;
  logic               w_spec_any, w_cmt_any;

  kvpt_cam #(.N(ENTRIES), .KEY_W(KEY_W), .BR_W(BR_W)) u_wr_cam (
    .vld_i(vld_q), .spec_i(spec_q), .key_i(key_q), .br_i(br_q),
    .q_key_i(wr_key), .q_br_i(wr_branch_i),
    .spec_hit_o(w_spec_hit), .cmt_hit_o(w_cmt_hit)
  );
  kvpt_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_wr_spec_pick (
    .vec_i(w_spec_hit), .idx_o(w_spec_idx), .any_o(w_spec_any)
  );
  kvpt_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_wr_cmt_pick (
    .vec_i(w_cmt_hit), .idx_o(w_cmt_idx), .any_o(w_cmt_any)
  );

  // free slot
  logic [IDX_W-1:0] slot_idx;
  logic             slot_any;
  kvpt_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_slot_pick (
    .vec_i(~vld_q), .idx_o(slot_idx), .any_o(slot_any)
  );

  // transaction
  logic [ENTRIES-1:0] sel, cmt_set, rb_clr, superseded, freed;
  logic [PAGES-1:0]   rel_pages;
  logic [CNT_W-1:0]   rel_cnt;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      sel[i] = txn_valid_i && vld_q[i] && spec_q[i] && txn_mask_i[br_q[i]];
  end
  assign cmt_set = txn_commit_i ? sel : '0;
  assign rb_clr  = txn_commit_i ? '0 : sel;

  // committed entries replaced by a committing entry with the same key
  for (genvar j = 0; j < ENTRIES; j++) begin : g_sup
    logic [ENTRIES-1:0] same_key;
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign same_key[i] = (key_q[i] == key_q[j]);
    end
    assign superseded[j] = vld_q[j] && !spec_q[j] && |(cmt_set & same_key);
  end
  assign freed = rb_clr | superseded;

  always_comb begin
    rel_pages = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (freed[i]) rel_pages[page_q[i]] = 1'b1;
  end
  assign rel_cnt = CNT_W'($countones(freed));

  // free pool
  logic            pool_empty, new_ent;
  logic [PG_W-1:0] pool_page;

  kvpt_free_pool #(.PAGES(PAGES), .PG_W(PG_W), .CNT_W(CNT_W)) u_pool (
    .clk_i, .rst_ni,
    .take_i(new_ent), .release_i(rel_pages), .release_cnt_i(rel_cnt),
    .page_o(pool_page), .empty_o(pool_empty), .count_o(free_cnt_o)
  );

  // write decision
  logic            wr_ok, want_ent, set_cow;
  logic [PG_W-1:0] res_page;
  wr_op_e          op;
  assign op = wr_op_e'(wr_op_i);

  always_comb begin
    wr_ok    = 1'b0;
    want_ent = 1'b0;
    set_cow  = 1'b0;
    res_page = '0;
    unique case (op)
      WR_ALLOC: begin
        wr_ok    = !w_spec_any && !w_cmt_any && slot_any && !pool_empty;
        want_ent = 1'b1;
        res_page = pool_page;
      end
      WR_SHARE: begin
        wr_ok    = w_cmt_any;
        set_cow  = 1'b1;
        res_page = page_q[w_cmt_idx];
      end
      WR_UPDATE: begin
        if (w_spec_any) begin
          wr_ok    = 1'b1;
          res_page = page_q[w_spec_idx];
        end else if (w_cmt_any && !cow_q[w_cmt_idx]) begin
          wr_ok    = 1'b1;
          res_page = page_q[w_cmt_idx];
        end else if (w_cmt_any) begin
          wr_ok    = slot_any && !pool_empty;
          want_ent = 1'b1;
          res_page = pool_page;
        end
      end
      default: wr_ok = 1'b0;
    endcase
    wr_ok = wr_ok && wr_valid_i && !txn_valid_i;
  end
  assign new_ent = wr_ok && want_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      spec_q <= '0;
      cow_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        key_q[i]  <= '0;
        br_q[i]   <= '0;
        page_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (freed[i])   vld_q[i]  <= 1'b0;
        if (cmt_set[i]) spec_q[i] <= 1'b0;
        if (wr_ok && set_cow && w_cmt_idx == IDX_W'(i)) cow_q[i] <= 1'b1;
        if (new_ent && slot_idx == IDX_W'(i)) begin
          vld_q[i]  <= 1'b1;
          spec_q[i] <= 1'b1;
          cow_q[i]  <= 1'b0;
          key_q[i]  <= wr_key;
          br_q[i]   <= wr_branch_i;
          page_q[i] <= pool_page;
        end
      end
    end
  end

  // registered results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_done_o <= 1'b0;
      lkp_hit_o  <= 1'b0;
      lkp_spec_o <= 1'b0;
      lkp_cow_o  <= 1'b0;
      lkp_page_o <= '0;
      wr_ack_o   <= 1'b0;
      wr_err_o   <= 1'b0;
      wr_page_o  <= '0;
    end else begin
      lkp_done_o <= lkp_valid_i;
      lkp_hit_o  <= lkp_valid_i && (l_spec_any || l_cmt_any);
      lkp_spec_o <= lkp_valid_i && l_spec_any;
      lkp_cow_o  <= lkp_valid_i && !l_spec_any && l_cmt_any && cow_q[l_cmt_idx];
      if (!lkp_valid_i)    lkp_page_o <= '0;
      else if (l_spec_any) lkp_page_o <= page_q[l_spec_idx];
      else if (l_cmt_any)  lkp_page_o <= page_q[l_cmt_idx];
      else                 lkp_page_o <= '0;
      wr_ack_o  <= wr_ok;
      wr_err_o  <= wr_valid_i && !wr_ok;
      wr_page_o <= wr_ok ? res_page : '0;
    end
  end

  assign lkp_addr_o = {lkp_page_o, {PAGE_LG_BYTES{1'b0}}};

  // R2
  lookup_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> lkp_done_o);
  // R2
  hit_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_done_o);
  // R9
  ack_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ack_o && wr_err_o));
  // R9
  refused_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_err_o && !$past(txn_valid_i)) |-> free_cnt_o == $past(free_cnt_o));
  // R7
  rollback_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(txn_valid_i && !txn_commit_i) |-> free_cnt_o >= $past(free_cnt_o));
  // R6
  commit_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(txn_valid_i && txn_commit_i) |-> free_cnt_o >= $past(free_cnt_o));
endmodule

// File: tb/kv_page_table_bench.sv
module kv_page_table_bench;
  localparam int SEQ_W = 4, LAYER_W = 6, POS_W = 12, BR_W = 6;
  localparam int ENTRIES = 4, PAGES = 4;
  localparam int PG_W = 2, CNT_W = 3, ADDR_W = PG_W + 12, NBR = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkp_valid = 0;
  logic [SEQ_W-1:0] lkp_seq = '0;
  logic [LAYER_W-1:0] lkp_layer = '0;
  logic [POS_W-1:0] lkp_pos = '0;
  logic [BR_W-1:0] lkp_br = '0;
  logic lkp_done, lkp_hit, lkp_spec, lkp_cow;
  logic [PG_W-1:0] lkp_page;
  logic [ADDR_W-1:0] lkp_addr;
  logic wr_valid = 0;
  logic [1:0] wr_op = '0;
  logic [SEQ_W-1:0] wr_seq = '0;
  logic [LAYER_W-1:0] wr_layer = '0;
  logic [POS_W-1:0] wr_pos = '0;
  logic [BR_W-1:0] wr_br = '0;
  logic wr_ack, wr_err;
  logic [PG_W-1:0] wr_page;
  logic txn_valid = 0, txn_commit = 0;
  logic [NBR-1:0] txn_mask = '0;
  logic [CNT_W-1:0] free_cnt;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  kv_page_table #(.SEQ_W(SEQ_W), .LAYER_W(LAYER_W), .POS_W(POS_W), .BR_W(BR_W),
                  .ENTRIES(ENTRIES), .PAGES(PAGES)) u_kv_page_table (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_seq_i(lkp_seq), .lkp_layer_i(lkp_layer),
    .lkp_pos_i(lkp_pos), .lkp_branch_i(lkp_br),
    .lkp_done_o(lkp_done), .lkp_hit_o(lkp_hit), .lkp_spec_o(lkp_spec),
    .lkp_cow_o(lkp_cow), .lkp_page_o(lkp_page), .lkp_addr_o(lkp_addr),
    .wr_valid_i(wr_valid), .wr_op_i(wr_op), .wr_seq_i(wr_seq),
    .wr_layer_i(wr_layer), .wr_pos_i(wr_pos), .wr_branch_i(wr_br),
    .wr_ack_o(wr_ack), .wr_err_o(wr_err), .wr_page_o(wr_page),
    .txn_valid_i(txn_valid), .txn_commit_i(txn_commit), .txn_mask_i(txn_mask),
    .free_cnt_o(free_cnt)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // key k -> seq k, layer k+1, pos k*100
  task automatic lookup(int k, int br);
    lkp_valid = 1; lkp_seq = SEQ_W'(k); lkp_layer = LAYER_W'(k + 1);
    lkp_pos = POS_W'(k * 100); lkp_br = BR_W'(br);
    @(negedge clk);
    lkp_valid = 0;
  endtask

  task automatic write(int op, int k, int br);
    wr_valid = 1; wr_op = 2'(op); wr_seq = SEQ_W'(k); wr_layer = LAYER_W'(k + 1);
    wr_pos = POS_W'(k * 100); wr_br = BR_W'(br);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic txn(bit commit, logic [NBR-1:0] mask);
    txn_valid = 1; txn_commit = commit; txn_mask = mask;
    @(negedge clk);
    txn_valid = 0;
  endtask

  task automatic expect_hit(string req, int pg, bit spec, bit cow);
    chk(req, "done", lkp_done, 1);
    chk(req, "hit", lkp_hit, 1);
    chk(req, "page", lkp_page, pg);
    chk(req, "spec", lkp_spec, spec);
    chk(req, "cow", lkp_cow, cow);
  endtask

  task automatic t_reset();
    chk("R1", "free count", free_cnt, PAGES);
    lookup(1, 0);
    chk("R2", "done", lkp_done, 1);
    chk("R1", "hit", lkp_hit, 0);
  endtask

  task automatic t_alloc_commit();
    write(0, 1, 5);
    chk("R3", "ack", wr_ack, 1);
    chk("R3", "page", wr_page, 0);
    chk("R10", "free", free_cnt, 3);
    lookup(1, 5);
    expect_hit("R3", 0, 1, 0);
    chk("R2", "addr", lkp_addr, 0);
    lookup(1, 6);
    chk("R3", "other branch miss", lkp_hit, 0);
    txn(1, 64'd1 << 5);
    lookup(1, 9);
    expect_hit("R6", 0, 0, 0);
    chk("R6", "free", free_cnt, 3);
  endtask

  task automatic t_share_cow();
    write(1, 1, 1);
    chk("R4", "ack", wr_ack, 1);
    chk("R4", "page", wr_page, 0);
    chk("R4", "free", free_cnt, 3);
    lookup(1, 2);
    expect_hit("R4", 0, 0, 1);
    write(2, 1, 1);
    chk("R5", "ack", wr_ack, 1);
    chk("R5", "private page", wr_page, 1);
    chk("R5", "free", free_cnt, 2);
    lookup(1, 1);
    expect_hit("R8", 1, 1, 0);
    chk("R2", "addr", lkp_addr, 4096);
    lookup(1, 2);
    expect_hit("R5", 0, 0, 1);
    write(2, 1, 1);
    chk("R5", "own update ack", wr_ack, 1);
    chk("R5", "own update page", wr_page, 1);
    chk("R5", "own update free", free_cnt, 2);
  endtask

  task automatic t_full();
    write(0, 2, 63);
    chk("R3", "page", wr_page, 2);
    write(0, 3, 7);
    chk("R3", "page", wr_page, 3);
    chk("R10", "free", free_cnt, 0);
    write(0, 4, 7);
    chk("R9", "full err", wr_err, 1);
    chk("R9", "full ack", wr_ack, 0);
    chk("R9", "free", free_cnt, 0);
    lookup(4, 7);
    chk("R9", "no entry", lkp_hit, 0);
  endtask

  task automatic t_rollback();
    txn(0, (64'd1 << 1) | (64'd1 << 63));
    chk("R7", "free", free_cnt, 2);
    lookup(1, 1);
    expect_hit("R7", 0, 0, 1);
    lookup(2, 63);
    chk("R7", "removed", lkp_hit, 0);
    lookup(3, 7);
    expect_hit("R7", 3, 1, 0);
  endtask

  task automatic t_commit_replace();
    write(2, 1, 7);
    chk("R5", "ack", wr_ack, 1);
    chk("R5", "page", wr_page, 1);
    chk("R10", "free", free_cnt, 1);
    txn(1, 64'd1 << 7);
    chk("R6", "free after replace", free_cnt, 2);
    lookup(1, 0);
    expect_hit("R6", 1, 0, 0);
    chk("R6", "addr", lkp_addr, 4096);
    lookup(3, 0);
    expect_hit("R6", 3, 0, 0);
  endtask

  task automatic t_refusals();
    write(0, 1, 3);
    chk("R9", "dup alloc err", wr_err, 1);
    write(1, 5, 3);
    chk("R9", "share miss err", wr_err, 1);
    write(3, 5, 3);
    chk("R9", "op3 err", wr_err, 1);
    chk("R9", "free", free_cnt, 2);
    wr_valid = 1; wr_op = 2'd0; wr_seq = 4'd5; wr_layer = 6'd6; wr_pos = 12'd500; wr_br = 6'd3;
    txn_valid = 1; txn_commit = 0; txn_mask = '1;
    @(negedge clk);
    wr_valid = 0; txn_valid = 0;
    chk("R9", "txn clash err", wr_err, 1);
    chk("R7", "rollback keeps committed", free_cnt, 2);
    lookup(5, 3);
    chk("R9", "no entry", lkp_hit, 0);
    lookup(3, 0);
    expect_hit("R7", 3, 0, 0);
    write(2, 1, 3);
    chk("R5", "in-place ack", wr_ack, 1);
    chk("R5", "in-place page", wr_page, 1);
    chk("R5", "in-place free", free_cnt, 2);
    write(0, 5, 3);
    chk("R3", "lowest free page", wr_page, 0);
    chk("R10", "free", free_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alloc_commit();
    t_share_cow();
    t_full();
    t_rollback();
    t_commit_replace();
    t_refusals();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule